// File: doc/BRIEF.md
# Bus Turnaround Timeout Timer

This block times the quiet gap between the end of one packet and the start of the next on a USB link. The protocol engine arms it when it expects a reply, for instance the data packet that should follow a SETUP token. The block then watches the decoded line state for the edge that marks the end of the previous packet. From that edge it counts bit-time strobes until either the next packet begins or the limit for the selected speed is used up.

At full speed, the gap opens when the line goes from SE0 to J and closes at the first J to K change. At high speed, the gap opens when the line enters squelch and closes when it leaves squelch. The two outcomes are reported as single-cycle pulses: "reply started" or "timed out". After either pulse the block stays idle until it is armed again.

Top module: `usb_turnaround_timer`

## Requirements
- R1: After reset, both pulse outputs are low and the block is idle. An idle block ignores line edges and strobes and produces no pulse.
- R2: A cycle with `arm_i` high clears the count, samples `hs_sel_i` (1 = high speed) and makes the block wait for a gap-opening edge. Arming again while waiting or counting restarts the sequence with the newly sampled speed.
- R3: Line state encoding is 00 = SE0, 01 = J, 10 = K, 11 = squelch. At full speed, a sampled change from SE0 to J opens the gap and starts counting from zero.
- R4: At full speed, a sampled change from J to K while counting produces a one-cycle `resp_start_o` pulse in the next cycle.
- R5: At full speed, the 18th counted strobe produces a one-cycle `timeout_o` pulse in the next cycle.
- R6: At high speed, a sampled change into squelch from any other state opens the gap and starts counting from zero.
- R7: At high speed, a sampled change out of squelch while counting produces a one-cycle `resp_start_o` pulse in the next cycle.
- R8: At high speed, the 816th counted strobe produces a one-cycle `timeout_o` pulse in the next cycle. The internal count never reaches the active limit.
- R9: If the gap-closing edge is sampled in the same cycle as the limit-reaching strobe, only `resp_start_o` pulses. The two pulses are never high together.
- R10: Only cycles in which `bit_stb_i` is high advance the count. Strobes given before the gap opens are not counted.
- R11: An arm request during counting discards the partial count. A full fresh limit is needed afterwards for a timeout.
- R12: After either pulse the block is disarmed. A later closing edge or further strobes produce no pulse until it is armed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Arm request from the protocol engine |
| hs_sel_i | input | 1 | Speed select, 1 = high speed; sampled on arm |
| line_state_i | input | 2 | Decoded line state: 00 SE0, 01 J, 10 K, 11 squelch |
| bit_stb_i | input | 1 | One-cycle strobe per bit time |
| timeout_o | output | 1 | One-cycle pulse when the gap limit is used up |
| resp_start_o | output | 1 | One-cycle pulse when the next packet begins |

## Verification
The edge register, the count, the sampled speed and the state all reach the ports only through when the two pulses happen. A wrong count or a wrong limit therefore shows up as `timeout_o` arriving on the wrong strobe. That is seen on the cycle after the offending strobe, and the bench records the strobe index at which each pulse appears. A stale edge register or a stuck state shows up as a missing reply pulse, or as a pulse appearing while idle, within one cycle of the line change. Re-arming with a new speed proves the speed was sampled afresh, because a timeout then appears only at the new limit.

// File: rtl/usb_ta_pkg.sv
package usb_ta_pkg;

   typedef enum logic [1:0] {
      LS_SE0 = 2'b00,
      LS_J   = 2'b01,
      LS_K   = 2'b10,
      LS_SQ  = 2'b11
   } line_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_COUNT = 2'd2
   } ta_state_t;

   // counter width: enough for the largest limit, never below MIN_W
   function automatic int cnt_width(input int max_lim, input int min_w);
      int w;
      w = $clog2(max_lim + 1);
      return (w > min_w) ? w : min_w;
   endfunction

endpackage

// File: rtl/usb_ta_line_edge.sv
module usb_ta_line_edge
   import usb_ta_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [1:0] line_i,
   output logic       fs_open_o,
   output logic       fs_close_o,
   output logic       hs_open_o,
   output logic       hs_close_o
);

   line_t prev_q;
   line_t cur;

   assign cur = line_t'(line_i);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) prev_q <= LS_J;
      else         prev_q <= cur;
   end

   assign fs_open_o  = (prev_q == LS_SE0) && (cur == LS_J);
   assign fs_close_o = (prev_q == LS_J)   && (cur == LS_K);
   assign hs_open_o  = (prev_q != LS_SQ)  && (cur == LS_SQ);
   assign hs_close_o = (prev_q == LS_SQ)  && (cur != LS_SQ);

   // R3 / R6: at most one kind of edge per cycle
   p_edge_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({fs_open_o, fs_close_o, hs_open_o, hs_close_o}));

endmodule

// File: rtl/usb_ta_bit_cnt.sv
module usb_ta_bit_cnt #(
   parameter int FS_LIMIT = 18,
   parameter int HS_LIMIT = 816,
   parameter int CNT_W    = 10
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic inc_i,
   input  logic hs_i,
   output logic hit_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit_w;

   generate
      if (FS_LIMIT == HS_LIMIT) begin : g_one_limit
         assign limit_w = CNT_W'(FS_LIMIT);
         logic unused_hs;
         assign unused_hs = hs_i;
      end else begin : g_two_limits
         assign limit_w = hs_i ? CNT_W'(HS_LIMIT) : CNT_W'(FS_LIMIT);
      end
   endgenerate

   assign hit_o = inc_i && (cnt_q == limit_w - CNT_W'(1));

   always_ff @(posedge clk_i) begin
      if (!rst_ni || clr_i) cnt_q <= '0;
      else if (hit_o)       cnt_q <= '0;
      else if (inc_i)       cnt_q <= cnt_q + CNT_W'(1);
   end

   // R8: count stays below the active limit
   p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q < limit_w);

   // R10: count moves only on a strobe or a clear
   p_cnt_on_stb_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!inc_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/usb_turnaround_timer.sv
module usb_turnaround_timer
   import usb_ta_pkg::*;
#(
   parameter int FS_LIMIT = 18,
   parameter int HS_LIMIT = 816,
   parameter int MIN_W    = 10
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       arm_i,
   input  logic       hs_sel_i,
   input  logic [1:0] line_state_i,
   input  logic       bit_stb_i,
   output logic       timeout_o,
   output logic       resp_start_o
);

   localparam int MAX_LIM = (HS_LIMIT > FS_LIMIT) ? HS_LIMIT : FS_LIMIT;
   localparam int CNT_W   = cnt_width(MAX_LIM, MIN_W);

   generate
      if (FS_LIMIT < 1 || HS_LIMIT < 1) begin : g_bad_limit
         $error("turnaround limits must be at least 1");
      end
      if (MIN_W < 1) begin : g_bad_width
         $error("MIN_W must be positive");
      end
   endgenerate

   ta_state_t state_q;
   logic      hs_q;
   logic      fs_open, fs_close, hs_open, hs_close;
   logic      open_edge, close_edge;
   logic      cnt_clr, cnt_inc, cnt_hit;

   usb_ta_line_edge u_edge (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .line_i     (line_state_i),
      .fs_open_o  (fs_open),
      .fs_close_o (fs_close),
      .hs_open_o  (hs_open),
      .hs_close_o (hs_close)
   );

   assign open_edge  = hs_q ? hs_open  : fs_open;
   assign close_edge = hs_q ? hs_close : fs_close;

   assign cnt_clr = arm_i || (state_q != ST_COUNT);
   assign cnt_inc = (state_q == ST_COUNT) && bit_stb_i && !close_edge && !arm_i;

   usb_ta_bit_cnt #(
      .FS_LIMIT (FS_LIMIT),
      .HS_LIMIT (HS_LIMIT),
      .CNT_W    (CNT_W)
   ) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (cnt_clr),
      .inc_i  (cnt_inc),
      .hs_i   (hs_q),
      .hit_o  (cnt_hit)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q      <= ST_IDLE;
         hs_q         <= 1'b0;
         timeout_o    <= 1'b0;
         resp_start_o <= 1'b0;
      end else begin
         timeout_o    <= 1'b0;
         resp_start_o <= 1'b0;
         if (arm_i) begin
            state_q <= ST_WAIT;
            hs_q    <= hs_sel_i;
         end else begin
            unique case (state_q)
               ST_WAIT: if (open_edge) state_q <= ST_COUNT;
               ST_COUNT: begin
                  if (close_edge) begin
                     resp_start_o <= 1'b1;
                     state_q      <= ST_IDLE;
                  end else if (cnt_hit) begin
                     timeout_o <= 1'b1;
                     state_q   <= ST_IDLE;
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   // R9: never both outcomes at once
   p_excl_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(timeout_o && resp_start_o));

   // R5: timeout is a single-cycle pulse
   p_to_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      timeout_o |=> !timeout_o);

   // R4: reply pulse is a single-cycle pulse
   p_resp_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      resp_start_o |=> !resp_start_o);

   // R10: a timeout follows a strobe
   p_to_after_stb_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      timeout_o |-> $past(bit_stb_i));

   // R12: after a pulse the block is disarmed
   p_idle_after_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (timeout_o || resp_start_o) |-> (state_q == ST_IDLE));

endmodule

// File: tb/usb_turnaround_timer_tb.sv
module usb_turnaround_timer_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int FS_LIM = 18;
   localparam int HS_LIM = 816;

   typedef struct packed {
      logic        hs;
      logic [11:0] nstb;
      logic [1:0]  mode;   // 0 no close, 1 close after strobes, 2 close with last strobe
      logic [11:0] exp_to; // strobe index of timeout, 0 = none
      logic        exp_rs;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 12'd18,  2'd0, 12'd18,  1'b0},  // R3 R5
      '{1'b0, 12'd17,  2'd1, 12'd0,   1'b1},  // R4
      '{1'b0, 12'd18,  2'd2, 12'd0,   1'b1},  // R9
      '{1'b0, 12'd18,  2'd1, 12'd18,  1'b0},  // R12
      '{1'b1, 12'd816, 2'd0, 12'd816, 1'b0},  // R6 R8
      '{1'b1, 12'd815, 2'd1, 12'd0,   1'b1},  // R7
      '{1'b1, 12'd816, 2'd2, 12'd0,   1'b1},  // R9
      '{1'b0, 12'd0,   2'd1, 12'd0,   1'b1},  // R4 immediate
      '{1'b1, 12'd40,  2'd1, 12'd0,   1'b1}   // R7
   };

   logic       clk = 1'b0;
   logic       rst_n;
   logic       arm;
   logic       hs_sel;
   logic [1:0] line;
   logic       stb;
   logic       timeout;
   logic       resp;

   int n_chk = 0;
   int n_bad = 0;
   int to_cnt, rs_cnt, to_at, stb_given;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   usb_turnaround_timer dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .arm_i        (arm),
      .hs_sel_i     (hs_sel),
      .line_state_i (line),
      .bit_stb_i    (stb),
      .timeout_o    (timeout),
      .resp_start_o (resp)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      if (timeout) begin to_cnt++; to_at = stb_given; end
      if (resp) rs_cnt++;
   endtask

   task automatic clear_obs();
      to_cnt = 0; rs_cnt = 0; to_at = 0; stb_given = 0;
   endtask

   task automatic do_arm(input logic hs);
      arm = 1'b1; hs_sel = hs; step(); arm = 1'b0;
   endtask

   task automatic open_gap(input logic hs);
      if (hs) begin line = 2'b10; step(); line = 2'b11; step(); end
      else    begin line = 2'b00; step(); line = 2'b01; step(); end
   endtask

   task automatic strobes(input int n);
      for (int i = 0; i < n; i++) begin
         stb = 1'b1; stb_given++; step(); stb = 1'b0; step();
      end
   endtask

   task automatic run_vec(input vec_t v, input int idx);
      clear_obs();
      line = 2'b10;
      do_arm(v.hs);
      open_gap(v.hs);
      for (int i = 1; i <= int'(v.nstb); i++) begin
         stb = 1'b1; stb_given++;
         if (i == int'(v.nstb) && v.mode == 2'd2) line = 2'b10;
         step(); stb = 1'b0; step();
      end
      if (v.mode == 2'd1) begin line = 2'b10; step(); step(); end
      step();
      $display("vector %0d", idx);
      check("R5/R8 timeout count", to_cnt, (v.exp_to != 0) ? 1 : 0);
      check("R5/R8 timeout strobe index", to_at, int'(v.exp_to));
      check("R4/R7/R9/R12 reply count", rs_cnt, int'(v.exp_rs));
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; arm = 1'b0; hs_sel = 1'b0; line = 2'b01; stb = 1'b0;
      clear_obs();
      step(); step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      check("R1 timeout after reset", int'(timeout), 0);
      check("R1 reply after reset", int'(resp), 0);

      // R1 idle block ignores edges and strobes
      clear_obs();
      open_gap(1'b0); strobes(20); line = 2'b10; step(); step();
      check("R1 idle timeouts", to_cnt, 0);
      check("R1 idle replies", rs_cnt, 0);

      // table walk
      for (int k = 0; k < NV; k++) run_vec(VECS[k], k);

      // R10 strobes before the gap opens are not counted
      clear_obs();
      line = 2'b01; step();
      do_arm(1'b0);
      strobes(10);
      open_gap(1'b0);
      strobes(17);
      check("R10 no early timeout", to_cnt, 0);
      strobes(1);
      check("R10 timeout at 28th strobe overall", to_at, 28);

      // R11 re-arm during counting discards the count
      clear_obs();
      do_arm(1'b0); open_gap(1'b0); strobes(10);
      do_arm(1'b0); open_gap(1'b0); strobes(17);
      check("R11 no timeout after re-arm", to_cnt, 0);
      strobes(1);
      check("R11 timeout at fresh limit", to_at, 28);

      // R2 re-arm samples a new speed
      clear_obs();
      do_arm(1'b0); open_gap(1'b0); strobes(5);
      do_arm(1'b1); open_gap(1'b1); strobes(30);
      check("R2 high-speed limit after re-arm", to_cnt, 0);
      line = 2'b10; step(); step();
      check("R2 reply at high speed", rs_cnt, 1);

      // R1 reset during counting
      clear_obs();
      do_arm(1'b0); open_gap(1'b0); strobes(10);
      rst_n = 1'b0; step(); rst_n = 1'b1; step();
      strobes(20); line = 2'b01; step(); line = 2'b10; step(); step();
      check("R1 reset disarms: timeouts", to_cnt, 0);
      check("R1 reset disarms: replies", rs_cnt, 0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule